// File: doc/BRIEF.md
# Misaligned Operand Access Splitter

This block sits between an execution unit and a data-side memory port that is one longword (four byte lanes) wide. It accepts one operand access at a time. Each access carries a byte address, an operand size of 8, 16, 32, 64 or 96 bits, and a kind: read, write or read-modify-write. The block works out whether the operand breaks the alignment rule for its size. It then walks the operand across the longwords it covers, one transfer per longword. Each transfer is offered on a valid/ready port with per-lane byte enables.

Write data is spread over the byte lanes of each transfer. Read data from each accepted transfer is packed into a right-justified result. Alongside the result, the block reports a misalignment flag and the number of extra execution cycles the misalignment costs. A read-modify-write fetches every longword before it stores any of them. A one-cycle done pulse marks the end of the access.

Top module: `opnd_split`

## Requirements
- R1: Size codes are 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit and 4 = 96-bit. An operand is misaligned when its address is not a multiple of 2 (16-bit), 4 (32-bit), 8 (64-bit) or 4 (96-bit). The flag appears on `rsp_misaligned`.
- R2: An 8-bit operand is never flagged as misaligned, and its penalty is always 0.
- R3: Kind codes are 0 = read, 1 = write, 2 = read-modify-write, and code 3 behaves as read. A misaligned read reports a penalty of 1.
- R4: A misaligned write or read-modify-write reports a penalty of 2. An aligned access of any kind reports 0.
- R5: The block issues one transfer for each longword that holds at least one operand byte, in ascending address order. `xf_addr` is the longword-aligned byte address. An aligned 32-bit, 64-bit or 96-bit operand therefore takes 1, 2 or 3 transfers. No other transfer is offered.
- R6: Operand byte i lives at address base+i. Byte enable bit l is set exactly when the byte at `xf_addr`+l belongs to the operand.
- R7: On a write transfer, lane l (bits 8l+7:8l) carries operand byte (`xf_addr`+l−base) of `req_wdata`, where byte 0 is bits 7:0. Lanes that are not enabled carry zero.
- R8: After a read or read-modify-write, byte i of `rsp_rdata` is the byte returned for address base+i, and all bits above the operand are zero. After a write, `rsp_rdata` is zero.
- R9: While `xf_valid` is high and `xf_ready` is low, the block holds the transfer valid and keeps its address, byte enables and direction unchanged.
- R10: A read-modify-write issues all of its read transfers, and then all of its write transfers over the same longwords.
- R11: `req_ready` is high only when no access is in progress, and a request presented while busy is ignored. `done` pulses for one cycle, in the cycle after the last transfer is accepted, and `req_ready` is high in that same cycle.
- R12: `rsp_misaligned`, `rsp_penalty` and `rsp_rdata` change only while an access is in progress. After `done` they hold until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request accepted when both high |
| req_addr | input | ADDR_W | Operand byte address |
| req_size | input | 3 | Operand size code |
| req_kind | input | 2 | Access kind code |
| req_wdata | input | 96 | Right-justified write operand |
| xf_valid | output | 1 | Transfer offered to the memory port |
| xf_ready | input | 1 | Memory port accepts the transfer |
| xf_addr | output | ADDR_W | Longword-aligned transfer address |
| xf_be | output | LANES | Byte enables |
| xf_we | output | 1 | Transfer is a write |
| xf_wdata | output | 8*LANES | Write data lanes |
| xf_rdata | input | 8*LANES | Read data, valid in the accept cycle |
| done | output | 1 | Access complete, one-cycle pulse |
| rsp_misaligned | output | 1 | Last accepted operand was misaligned |
| rsp_penalty | output | 2 | Extra execution cycles for the last access |
| rsp_rdata | output | 96 | Right-justified read result |

## Verification
Most internal faults show up at the ports within one clock. A wrong longword pointer gives a wrong `xf_addr` on the next offered transfer. A wrong base or size register gives wrong byte enables or lane data on the first transfer. A wrong phase bit in a read-modify-write flips `xf_we` on the next beat. A corrupt merge index shows up only at `done`, as a wrong `rsp_rdata`. For that reason the reference model also compares the result in every idle cycle. A stuck or early state exit appears as a missing or extra transfer, or as a `done` pulse one cycle off. The model checks both in every cycle.

// File: rtl/opnd_split_pkg.sv
package opnd_split_pkg;

   localparam int MAX_BYTES = 12;
   localparam int OPW       = 8 * MAX_BYTES;

   typedef enum logic [2:0] {
      SZ_BYTE = 3'd0,
      SZ_HALF = 3'd1,
      SZ_LONG = 3'd2,
      SZ_DBL  = 3'd3,
      SZ_TRI  = 3'd4
   } op_size_e;

   typedef enum logic [1:0] {
      K_READ  = 2'd0,
      K_WRITE = 2'd1,
      K_RMW   = 2'd2
   } op_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_STORE = 2'd2
   } seq_state_e;

   // bytes occupied by an operand of a given size code
   function automatic logic [3:0] size_bytes(input logic [2:0] sz);
      case (sz)
         SZ_HALF: return 4'd2;
         SZ_LONG: return 4'd4;
         SZ_DBL:  return 4'd8;
         SZ_TRI:  return 4'd12;
         default: return 4'd1;
      endcase
   endfunction

   // address granule an operand must sit on to count as aligned
   function automatic logic [3:0] granule_bytes(input logic [2:0] sz);
      case (sz)
         SZ_HALF: return 4'd2;
         SZ_LONG: return 4'd4;
         SZ_DBL:  return 4'd8;
         SZ_TRI:  return 4'd4;
         default: return 4'd1;
      endcase
   endfunction

endpackage

// File: rtl/opnd_split_align.sv
module opnd_split_align
   import opnd_split_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input  logic [ADDR_W-1:0]                   addr,
   input  logic [2:0]                          size,
   input  logic [1:0]                          kind,
   output logic                                misaligned,
   output logic [1:0]                          penalty,
   output logic [3:0]                          nbytes,
   output logic [ADDR_W-$clog2(LANES)-1:0]     first_word,
   output logic [ADDR_W-$clog2(LANES)-1:0]     last_word
);
   localparam int WB = $clog2(LANES);

   logic [3:0]        gran_mask;
   logic [ADDR_W-1:0] end_addr;
   logic              costly_kind;

   always_comb begin
      nbytes      = size_bytes(size);
      gran_mask   = granule_bytes(size) - 4'd1;
      misaligned  = (addr[2:0] & gran_mask[2:0]) != 3'd0;
      costly_kind = (kind == K_WRITE) || (kind == K_RMW);
      if (!misaligned)     penalty = 2'd0;
      else if (costly_kind) penalty = 2'd2;
      else                 penalty = 2'd1;
      end_addr    = addr + ADDR_W'(nbytes) - ADDR_W'(1);
      first_word  = addr[ADDR_W-1:WB];
      last_word   = end_addr[ADDR_W-1:WB];
   end

endmodule

// File: rtl/opnd_split_lanes.sv
module opnd_split_lanes
   import opnd_split_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input  logic [ADDR_W-$clog2(LANES)-1:0] cur_word,
   input  logic [ADDR_W-1:0]               base,
   input  logic [3:0]                      nbytes,
   input  logic [OPW-1:0]                  wdata,
   output logic [LANES-1:0]                be,
   output logic [8*LANES-1:0]              lane_wdata
);
   localparam int WB = $clog2(LANES);

   for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
      localparam logic [WB-1:0] LANE_IDX = WB'(gl);
      logic [ADDR_W-1:0] offs;
      logic [7:0]        pick;

      assign offs      = {cur_word, LANE_IDX} - base;
      assign be[gl]    = offs < ADDR_W'(nbytes);

      always_comb begin
         pick = 8'h00;
         for (int j = 0; j < MAX_BYTES; j++) begin
            if (offs == ADDR_W'(j)) pick = wdata[8*j +: 8];
         end
      end

      assign lane_wdata[8*gl +: 8] = be[gl] ? pick : 8'h00;
   end

endmodule

// File: rtl/opnd_split_merge.sv
module opnd_split_merge
   import opnd_split_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clr,
   input  logic                            cap,
   input  logic [ADDR_W-$clog2(LANES)-1:0] cur_word,
   input  logic [ADDR_W-1:0]               base,
   input  logic [3:0]                      nbytes,
   input  logic [8*LANES-1:0]              rdata,
   output logic [OPW-1:0]                  result
);
   localparam int WB = $clog2(LANES);

   for (genvar gb = 0; gb < MAX_BYTES; gb++) begin : g_byte
      logic [ADDR_W-1:0] byte_addr;
      logic [WB+2:0]     shift;
      logic              hit;

      assign byte_addr = base + ADDR_W'(gb);
      assign shift     = {byte_addr[WB-1:0], 3'b000};
      assign hit       = cap && (4'(gb) < nbytes)
                         && (byte_addr[ADDR_W-1:WB] == cur_word);

      always_ff @(posedge clk) begin
         if (!rst_n)   result[8*gb +: 8] <= 8'h00;
         else if (clr) result[8*gb +: 8] <= 8'h00;
         else if (hit) result[8*gb +: 8] <= rdata[shift +: 8];
      end
   end

endmodule

// File: rtl/opnd_split.sv
module opnd_split
   import opnd_split_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [2:0]           req_size,
   input  logic [1:0]           req_kind,
   input  logic [95:0]          req_wdata,
   output logic                 xf_valid,
   input  logic                 xf_ready,
   output logic [ADDR_W-1:0]    xf_addr,
   output logic [LANES-1:0]     xf_be,
   output logic                 xf_we,
   output logic [8*LANES-1:0]   xf_wdata,
   input  logic [8*LANES-1:0]   xf_rdata,
   output logic                 done,
   output logic                 rsp_misaligned,
   output logic [1:0]           rsp_penalty,
   output logic [95:0]          rsp_rdata
);
   localparam int WB     = $clog2(LANES);
   localparam int WORD_W = ADDR_W - WB;

   // elaboration-time parameter checks
   if (LANES < 2 || LANES > 16 || (1 << WB) != LANES) begin : g_bad_lanes
      $error("opnd_split: LANES must be a power of two in 2..16");
   end
   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr
      $error("opnd_split: ADDR_W must lie in 8..64");
   end

   seq_state_e         state_q;
   logic [ADDR_W-1:0]  base_q;
   logic [3:0]         nbytes_q;
   logic               rmw_q;
   logic [OPW-1:0]     wdata_q;
   logic [WORD_W-1:0]  cur_word_q, first_q, last_q;
   logic               mis_q;
   logic [1:0]         pen_q;
   logic               done_q;

   logic               dec_mis;
   logic [1:0]         dec_pen;
   logic [3:0]         dec_nbytes;
   logic [WORD_W-1:0]  dec_first, dec_last;

   logic               req_fire, xf_fire, last_beat;

   opnd_split_align #(.ADDR_W(ADDR_W), .LANES(LANES)) u_align (
      .addr       (req_addr),
      .size       (req_size),
      .kind       (req_kind),
      .misaligned (dec_mis),
      .penalty    (dec_pen),
      .nbytes     (dec_nbytes),
      .first_word (dec_first),
      .last_word  (dec_last)
   );

   opnd_split_lanes #(.ADDR_W(ADDR_W), .LANES(LANES)) u_lanes (
      .cur_word   (cur_word_q),
      .base       (base_q),
      .nbytes     (nbytes_q),
      .wdata      (wdata_q),
      .be         (xf_be),
      .lane_wdata (xf_wdata)
   );

   opnd_split_merge #(.ADDR_W(ADDR_W), .LANES(LANES)) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (req_fire),
      .cap      (xf_fire && (state_q == ST_FETCH)),
      .cur_word (cur_word_q),
      .base     (base_q),
      .nbytes   (nbytes_q),
      .rdata    (xf_rdata),
      .result   (rsp_rdata)
   );

   assign req_ready = (state_q == ST_IDLE);
   assign req_fire  = req_valid && req_ready;
   assign xf_valid  = (state_q != ST_IDLE);
   assign xf_we     = (state_q == ST_STORE);
   assign xf_addr   = {cur_word_q, {WB{1'b0}}};
   assign xf_fire   = xf_valid && xf_ready;
   assign last_beat = (cur_word_q == last_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         base_q     <= '0;
         nbytes_q   <= 4'd1;
         rmw_q      <= 1'b0;
         wdata_q    <= '0;
         cur_word_q <= '0;
         first_q    <= '0;
         last_q     <= '0;
         mis_q      <= 1'b0;
         pen_q      <= 2'd0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_fire) begin
                  base_q     <= req_addr;
                  nbytes_q   <= dec_nbytes;
                  rmw_q      <= (req_kind == K_RMW);
                  wdata_q    <= req_wdata;
                  cur_word_q <= dec_first;
                  first_q    <= dec_first;
                  last_q     <= dec_last;
                  mis_q      <= dec_mis;
                  pen_q      <= dec_pen;
                  state_q    <= (req_kind == K_WRITE) ? ST_STORE : ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (xf_fire) begin
                  if (!last_beat) begin
                     cur_word_q <= cur_word_q + WORD_W'(1);
                  end else if (rmw_q) begin
                     cur_word_q <= first_q;
                     state_q    <= ST_STORE;
                  end else begin
                     state_q    <= ST_IDLE;
                     done_q     <= 1'b1;
                  end
               end
            end
            ST_STORE: begin
               if (xf_fire) begin
                  if (!last_beat) begin
                     cur_word_q <= cur_word_q + WORD_W'(1);
                  end else begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign done           = done_q;
   assign rsp_misaligned = mis_q;
   assign rsp_penalty    = pen_q;

endmodule

// File: rtl/opnd_split_chk.sv
module opnd_split_chk #(
   parameter int ADDR_W = 32,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              xf_valid,
   input logic              xf_ready,
   input logic [ADDR_W-1:0] xf_addr,
   input logic [LANES-1:0]  xf_be,
   input logic              xf_we,
   input logic              done,
   input logic              rsp_misaligned,
   input logic [1:0]        rsp_penalty
);

   AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      xf_valid && !xf_ready |=> xf_valid && $stable(xf_addr) && $stable(xf_be) && $stable(xf_we)); // R9

   AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      xf_valid |-> !req_ready); // R11

   AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready && !xf_valid); // R11

   AST_ALIGNED_NO_COST: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_misaligned |-> rsp_penalty == 2'd0); // R4

   AST_SOME_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      xf_valid |-> xf_be != '0); // R6

   AST_READ_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
      xf_valid && xf_ready && !xf_we |=>
         !xf_valid || xf_we || (xf_addr == $past(xf_addr) + ADDR_W'(LANES))); // R5

   AST_NO_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      xf_valid && xf_ready && xf_we |=> !xf_valid || xf_we); // R10

   AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_ready) |=> $stable(rsp_penalty) && $stable(rsp_misaligned)); // R12

endmodule

bind opnd_split opnd_split_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .xf_valid       (xf_valid),
   .xf_ready       (xf_ready),
   .xf_addr        (xf_addr),
   .xf_be          (xf_be),
   .xf_we          (xf_we),
   .done           (done),
   .rsp_misaligned (rsp_misaligned),
   .rsp_penalty    (rsp_penalty)
);

// File: tb/opnd_split_tb_top.sv
module opnd_split_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int L  = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic          req_ready;
   logic [AW-1:0] req_addr;
   logic [2:0]    req_size;
   logic [1:0]    req_kind;
   logic [95:0]   req_wdata;
   logic          xf_valid;
   logic          xf_ready;
   logic [AW-1:0] xf_addr;
   logic [L-1:0]  xf_be;
   logic          xf_we;
   logic [8*L-1:0] xf_wdata;
   logic [8*L-1:0] xf_rdata;
   logic          done;
   logic          rsp_misaligned;
   logic [1:0]    rsp_penalty;
   logic [95:0]   rsp_rdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   opnd_split #(.ADDR_W(AW), .LANES(L)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_size(req_size), .req_kind(req_kind), .req_wdata(req_wdata),
      .xf_valid(xf_valid), .xf_ready(xf_ready), .xf_addr(xf_addr),
      .xf_be(xf_be), .xf_we(xf_we), .xf_wdata(xf_wdata), .xf_rdata(xf_rdata),
      .done(done), .rsp_misaligned(rsp_misaligned), .rsp_penalty(rsp_penalty),
      .rsp_rdata(rsp_rdata)
   );

   typedef struct packed {
      logic [31:0] a;
      logic [3:0]  be;
      logic        we;
      logic [31:0] wd;
   } xfr_t;

   xfr_t        q[$];
   int          checks = 0;
   int          fails  = 0;
   bit          model_idle = 1'b1;
   bit          exp_done   = 1'b0;
   logic [95:0] exp_rd  = '0;
   logic        exp_mis = 1'b0;
   logic [1:0]  exp_pen = 2'd0;
   logic [15:0] lfsr = 16'hACE1;

   function automatic logic [7:0] memb(input logic [31:0] a);
      logic [31:0] t;
      t = a * 32'd37 + 32'd11;
      return t[7:0];
   endfunction

   // memory model: each lane returns the byte stored at its address
   always_comb begin
      for (int l = 0; l < L; l++) xf_rdata[8*l +: 8] = memb(xf_addr + 32'(l));
   end

   task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cycle();
      @(negedge clk);
      chk(done === exp_done, "R11 done pulse", 96'(done), 96'(exp_done));
      chk(req_ready === model_idle, "R11 req_ready", 96'(req_ready), 96'(model_idle));
      chk(rsp_misaligned === exp_mis, "R1 R2 R12 misaligned flag", 96'(rsp_misaligned), 96'(exp_mis));
      chk(rsp_penalty === exp_pen, "R3 R4 R12 penalty", 96'(rsp_penalty), 96'(exp_pen));
      if (model_idle) chk(rsp_rdata === exp_rd, "R8 R12 result", rsp_rdata, exp_rd);
      if (q.size() != 0) begin
         chk(xf_valid === 1'b1, "R5 R9 transfer valid", 96'(xf_valid), 96'(1));
         chk(xf_addr === q[0].a, "R5 R9 transfer address", 96'(xf_addr), 96'(q[0].a));
         chk(xf_be === q[0].be, "R6 R9 byte enables", 96'(xf_be), 96'(q[0].be));
         chk(xf_we === q[0].we, "R10 transfer direction", 96'(xf_we), 96'(q[0].we));
         if (q[0].we) chk(xf_wdata === q[0].wd, "R7 write lanes", 96'(xf_wdata), 96'(q[0].wd));
      end else begin
         chk(xf_valid === 1'b0, "R5 no extra transfer", 96'(xf_valid), 96'(0));
      end
      exp_done  = 1'b0;
      req_valid = 1'b0;
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      xf_ready  = lfsr[0] | lfsr[3];
      if (q.size() != 0 && xf_ready) begin
         void'(q.pop_front());
         if (q.size() == 0) begin
            exp_done   = 1'b1;
            model_idle = 1'b1;
         end
      end
      // R11: a request offered while busy must be ignored
      if (!model_idle && lfsr[5]) begin
         req_valid = 1'b1;
         req_addr  = {lfsr, lfsr};
         req_size  = 3'd4;
         req_kind  = 2'd1;
         req_wdata = {3{lfsr, ~lfsr}};
      end
   endtask

   task automatic issue(input logic [2:0] sz, input logic [1:0] kd,
                        input logic [31:0] base, input logic [95:0] wd);
      int          n, gran, cnt, passes;
      logic [31:0] first, last, w, offs;
      xfr_t        t;
      n    = (sz == 3'd1) ? 2 : (sz == 3'd2) ? 4 : (sz == 3'd3) ? 8 : (sz == 3'd4) ? 12 : 1;
      gran = (sz == 3'd4) ? 4 : n;
      req_valid = 1'b1;
      req_addr  = base;
      req_size  = sz;
      req_kind  = kd;
      req_wdata = wd;
      exp_mis = (base % 32'(gran)) != 0;
      exp_pen = !exp_mis ? 2'd0 : (kd == 2'd1 || kd == 2'd2) ? 2'd2 : 2'd1;
      exp_rd  = '0;
      if (kd != 2'd1) begin
         for (int i = 0; i < n; i++) exp_rd[8*i +: 8] = memb(base + 32'(i));
      end
      first  = base >> 2;
      last   = (base + 32'(n) - 32'd1) >> 2;
      cnt    = int'(last - first) + 1;
      passes = (kd == 2'd2) ? 2 : 1;
      for (int p = 0; p < passes; p++) begin
         for (int k = 0; k < cnt; k++) begin
            w    = first + 32'(k);
            t.a  = w << 2;
            t.we = (kd == 2'd1) || (kd == 2'd2 && p == 1);
            t.be = '0;
            t.wd = '0;
            for (int l = 0; l < L; l++) begin
               offs = t.a + 32'(l) - base;
               if (offs < 32'(n)) begin
                  t.be[l] = 1'b1;
                  t.wd[8*l +: 8] = wd[8*offs[3:0] +: 8];
               end
            end
            q.push_back(t);
         end
      end
      model_idle = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int nreq;
      logic [31:0] bases[2];
      bases[0] = 32'h0000_0100;
      bases[1] = 32'h0000_7FF0;
      rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
      req_kind = '0; req_wdata = '0; xf_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cycle();   // reset state: idle, no transfer, zero responses (R11 R12)
      nreq = 0;
      for (int b = 0; b < 2; b++) begin
         for (int off = 0; off < 8; off++) begin
            for (int sz = 0; sz < 5; sz++) begin
               for (int kd = 0; kd < 4; kd++) begin
                  nreq++;
                  issue(3'(sz), 2'(kd), bases[b] + 32'(off),
                        {32'hC0DE_0000 | 32'(nreq), 32'h1234_5678 ^ 32'(nreq * 7), 32'hA5A5_0000 | 32'(off)});
                  do cycle(); while (!model_idle);
                  cycle();
               end
            end
         end
      end
      repeat (3) cycle();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule